// File: doc/BRIEF.md
# Program Counter with Return Stack

This block holds the 15-bit instruction address of a small 8-bit controller core and decides each clock cycle where the next instruction comes from. A 3-bit control code, produced by the instruction decoder, selects one action per cycle. The PC can hold, step forward by one, take an absolute jump, call a subroutine, return from one, have its low byte overwritten by the accumulator, or have the accumulator added to it as an unsigned offset for computed table jumps.

Return addresses live in an internal circular stack, eight entries deep by default. A call saves the address that follows the call, and a return restores the newest saved address. When the stack is full, a further call overwrites the oldest entry. A return from an empty stack yields address zero. Level flags and single-cycle fault strobes report the stack's condition. Reset is asynchronous and active low. It wins over any control code that is present.

Top module: `pc_seq_unit`

## Requirements
- R1: While reset is low, and after it is released, the PC reads 0x0000 and the stack reports empty and not full.
- R2: Code 0 (hold) and code 7 (reserved) leave the PC unchanged and do not touch the stack.
- R3: Code 1 (step) adds one to the PC, and 0x7FFF is followed by 0x0000.
- R4: Code 2 (jump) loads the PC with the jump target input on the next edge.
- R5: Code 3 (call) saves PC+1 (modulo 2^15) on the stack and loads the jump target.
- R6: Code 4 (return) loads the PC with the most recently saved address and removes that address from the stack.
- R7: Code 5 (low-byte load) puts the accumulator in PC bits 7:0 and keeps bits 14:8.
- R8: Code 6 (offset add) adds the accumulator to the PC as an unsigned 8-bit value, and any carry out of bit 14 is dropped.
- R9: The empty flag is high exactly when no addresses are saved, and the full flag is high exactly when eight are saved.
- R10: A call while the stack is full pulses the overflow strobe in that cycle and discards the oldest saved address. The eight newest addresses then come back in reverse order.
- R11: A return while the stack is empty pulses the underflow strobe in that cycle, loads 0x0000 into the PC, and the stack stays empty.
- R12: Driving reset low in the middle of a cycle that carries any control code clears the PC and empties the stack. The code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Control code: 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 low-byte load, 6 offset add, 7 reserved |
| acc_i | input | 8 | Accumulator byte |
| target_i | input | 15 | Jump and call target address |
| pc_o | output | 15 | Current program counter |
| stk_full_o | output | 1 | Stack holds its maximum number of addresses |
| stk_empty_o | output | 1 | Stack holds no address |
| stk_ovf_o | output | 1 | A call is arriving while the stack is full (combinational) |
| stk_unf_o | output | 1 | A return is arriving while the stack is empty (combinational) |

## Verification
The bench uses the default build: a 15-bit PC, an 8-bit accumulator and an eight-entry stack. With these sizes, every accumulator value can be swept through the low-byte load and the offset add. The offset add is swept from base addresses that force a carry into bit 8 and out of bit 14. The eight-entry stack is small enough to fill past capacity and then drain past empty within one run, so the overwrite of the oldest entry and the zero returned on underflow are both reached. A shifting array in the bench models the stack, independently of the design's circular pointer.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        PCOP_HOLD = 3'd0,
        PCOP_INC  = 3'd1,
        PCOP_JUMP = 3'd2,
        PCOP_CALL = 3'd3,
        PCOP_RET  = 3'd4,
        PCOP_LDLO = 3'd5,
        PCOP_ADDA = 3'd6,
        PCOP_RSVD = 3'd7
    } pc_op_e;

    // decoded request set, resolved by priority in the next-address logic
    typedef struct packed {
        logic ret;
        logic call;
        logic jump;
        logic ldlo;
        logic adda;
        logic inc;
    } pc_req_t;

endpackage

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
#(
    parameter int PC_W  = 15,
    parameter int ACC_W = 8
) (
    input  pc_op_e             op,
    input  logic [PC_W-1:0]    pc,
    input  logic [ACC_W-1:0]   acc,
    input  logic [PC_W-1:0]    target,
    input  logic [PC_W-1:0]    pop_data,
    output logic [PC_W-1:0]    pc_nxt,
    output logic               push,
    output logic               pop,
    output logic [PC_W-1:0]    push_data
);

    localparam int HI_W = PC_W - ACC_W;

    pc_req_t         req;
    logic [PC_W-1:0] pc_plus1;
    logic [PC_W-1:0] pc_plus_acc;
    logic [PC_W-1:0] pc_lo_load;

    always_comb begin
        req      = '0;
        req.ret  = (op == PCOP_RET);
        req.call = (op == PCOP_CALL);
        req.jump = (op == PCOP_JUMP);
        req.ldlo = (op == PCOP_LDLO);
        req.adda = (op == PCOP_ADDA);
        req.inc  = (op == PCOP_INC);
    end

    always_comb begin
        pc_plus1    = pc + PC_W'(1);
        pc_plus_acc = pc + PC_W'(acc);
        pc_lo_load  = {pc[PC_W-1 -: HI_W], acc};
    end

    // priority: return, then call/jump, then register writes, then step
    always_comb begin
        pc_nxt    = pc;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc_plus1;
        if (req.ret) begin
            pop    = 1'b1;
            pc_nxt = pop_data;
        end else if (req.call) begin
            push   = 1'b1;
            pc_nxt = target;
        end else if (req.jump) begin
            pc_nxt = target;
        end else if (req.ldlo) begin
            pc_nxt = pc_lo_load;
        end else if (req.adda) begin
            pc_nxt = pc_plus_acc;
        end else if (req.inc) begin
            pc_nxt = pc_plus1;
        end
    end

    always_comb begin
        assert ($onehot0(req))
            else $error("p_onehot_req_r2: more than one request decoded");
        assert (!(push && pop))
            else $error("p_no_push_pop_r6: push and pop together");
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int PC_W  = 15,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [PC_W-1:0]  push_data,
    output logic [PC_W-1:0]  pop_data,
    output logic             full,
    output logic             empty,
    output logic             ovf,
    output logic             unf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [PTR_W-1:0]           top;
        logic [CNT_W-1:0]           cnt;
    } stk_t;

    stk_t             st_d, st_q;
    logic [PTR_W-1:0] top_inc;
    logic [PTR_W-1:0] top_dec;

    always_comb begin
        top_inc = (st_q.top == PTR_LAST) ? '0 : st_q.top + PTR_W'(1);
        top_dec = (st_q.top == '0) ? PTR_LAST : st_q.top - PTR_W'(1);
    end

    always_comb begin
        full     = (st_q.cnt == CNT_MAX);
        empty    = (st_q.cnt == '0);
        ovf      = push && full;
        unf      = pop && empty;
        pop_data = empty ? '0 : st_q.mem[top_dec];
    end

    always_comb begin
        st_d = st_q;
        if (push) begin
            // on a full stack the write slot holds the oldest entry
            st_d.mem[st_q.top] = push_data;
            st_d.top           = top_inc;
            if (!full) st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            st_d.top = top_dec;
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_push_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    p_ovf_stays_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> full);

    p_unf_stays_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> empty);

    p_pop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pcs_pkg::*;
#(
    parameter int PC_W      = 15,
    parameter int ACC_W     = 8,
    parameter int STK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [PC_W-1:0]   target_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              stk_full_o,
    output logic              stk_empty_o,
    output logic              stk_ovf_o,
    output logic              stk_unf_o
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pcs_state_t;

    pcs_state_t      s_d, s_q;
    pc_op_e          op;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] pop_data;
    logic [PC_W-1:0] push_data;
    logic            push;
    logic            pop;

    assign op = pc_op_e'(op_i);

    pcs_next #(
        .PC_W  (PC_W),
        .ACC_W (ACC_W)
    ) u_next (
        .op        (op),
        .pc        (s_q.pc),
        .acc       (acc_i),
        .target    (target_i),
        .pop_data  (pop_data),
        .pc_nxt    (pc_nxt),
        .push      (push),
        .pop       (pop),
        .push_data (push_data)
    );

    pcs_stack #(
        .PC_W  (PC_W),
        .DEPTH (STK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .pop_data  (pop_data),
        .full      (stk_full_o),
        .empty     (stk_empty_o),
        .ovf       (stk_ovf_o),
        .unf       (stk_unf_o)
    );

    always_comb begin
        s_d    = s_q;
        s_d.pc = pc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pc_o = s_q.pc;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd7) |=> (pc_o == $past(pc_o)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1))));

    p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> (pc_o == $past(target_i)));

    p_call_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> (pc_o == $past(target_i) && !stk_empty_o));

    p_ldlo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> (pc_o[ACC_W-1:0] == $past(acc_i) &&
                            pc_o[PC_W-1:ACC_W] == $past(pc_o[PC_W-1:ACC_W])));

    p_unf_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf_o |=> (pc_o == '0));

endmodule

// File: tb/sim_pc_seq_unit.sv
`timescale 1ns/1ps
module sim_pc_seq_unit;

    localparam int PC_W  = 15;
    localparam int ACC_W = 8;
    localparam int DEPTH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op_i = 3'd0;
    logic [ACC_W-1:0]  acc_i = '0;
    logic [PC_W-1:0]   target_i = '0;
    logic [PC_W-1:0]   pc_o;
    logic              stk_full_o, stk_empty_o, stk_ovf_o, stk_unf_o;

    int n_chk = 0;
    int n_fail = 0;

    // independent model: PC and a shifting stack array
    logic [PC_W-1:0] m_pc = '0;
    logic [PC_W-1:0] m_stk [DEPTH];
    int              m_cnt = 0;

    always #5 clk = ~clk;

    pc_seq_unit u0 (
        .clk, .rst_n, .op_i, .acc_i, .target_i,
        .pc_o, .stk_full_o, .stk_empty_o, .stk_ovf_o, .stk_unf_o
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd1: return "R3 step";
            3'd2: return "R4 jump";
            3'd3: return "R5 call";
            3'd4: return "R6 return";
            3'd5: return "R7 low-byte load";
            3'd6: return "R8 offset add";
            default: return "R2 hold";
        endcase
    endfunction

    task automatic check_flags();
        chk("R9 empty flag", int'(stk_empty_o), int'(m_cnt == 0));
        chk("R9 full flag",  int'(stk_full_o),  int'(m_cnt == DEPTH));
    endtask

    task automatic step(input logic [2:0] op, input logic [7:0] acc,
                        input logic [PC_W-1:0] tgt);
        logic [PC_W-1:0] exp_pc;
        @(negedge clk);
        op_i = op; acc_i = acc; target_i = tgt;
        #1;
        chk("R10 overflow strobe",  int'(stk_ovf_o), int'(op == 3'd3 && m_cnt == DEPTH));
        chk("R11 underflow strobe", int'(stk_unf_o), int'(op == 3'd4 && m_cnt == 0));
        exp_pc = m_pc;
        case (op)
            3'd1: exp_pc = PC_W'(m_pc + 1);
            3'd2: exp_pc = tgt;
            3'd3: begin
                if (m_cnt == DEPTH) begin
                    for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
                    m_stk[DEPTH-1] = PC_W'(m_pc + 1);
                end else begin
                    m_stk[m_cnt] = PC_W'(m_pc + 1);
                    m_cnt++;
                end
                exp_pc = tgt;
            end
            3'd4: begin
                if (m_cnt == 0) exp_pc = '0;
                else begin
                    m_cnt--;
                    exp_pc = m_stk[m_cnt];
                end
            end
            3'd5: exp_pc = {m_pc[PC_W-1:8], acc};
            3'd6: exp_pc = PC_W'(int'(m_pc) + int'(acc));
            default: exp_pc = m_pc;
        endcase
        m_pc = exp_pc;
        @(posedge clk);
        #1;
        chk(op_tag(op), int'(pc_o), int'(exp_pc));
        check_flags();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        #22;
        chk("R1 pc in reset", int'(pc_o), 0);
        chk("R1 empty in reset", int'(stk_empty_o), 1);
        chk("R1 full in reset", int'(stk_full_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 pc after release", int'(pc_o), 0);

        // R2 hold and reserved code
        step(3'd0, 8'h55, 15'h1111);
        step(3'd7, 8'hAA, 15'h2222);
        step(3'd1, 8'h00, 15'h0);
        step(3'd7, 8'h00, 15'h3333);
        step(3'd0, 8'h00, 15'h0);

        // R3 step with wrap at the top of the space
        step(3'd2, 8'h00, 15'h7FFD);
        for (int i = 0; i < 5; i++) step(3'd1, 8'h00, 15'h0);

        // R7 every accumulator value through the low-byte load
        step(3'd2, 8'h00, 15'h5A34);
        for (int a = 0; a < 256; a++) step(3'd5, 8'(a), 15'h0);
        step(3'd2, 8'h00, 15'h7F00);
        for (int a = 255; a >= 0; a--) step(3'd5, 8'(a), 15'h0);

        // R8 offset add swept over all values from carry-prone bases
        for (int b = 0; b < 4; b++) begin
            logic [PC_W-1:0] base;
            case (b)
                0: base = 15'h0000;
                1: base = 15'h12FF;
                2: base = 15'h7F80;
                default: base = 15'h7FFF;
            endcase
            for (int a = 0; a < 256; a++) begin
                step(3'd2, 8'h00, base);
                step(3'd6, 8'(a), 15'h0);
            end
        end

        // R5, R6, R9, R10: fill past capacity, then drain past empty (R11)
        step(3'd2, 8'h00, 15'h0100);
        for (int k = 0; k < DEPTH + 2; k++) begin
            step(3'd3, 8'h00, PC_W'(15'h0200 + k * 15'h0111));
            step(3'd1, 8'h00, 15'h0);
        end
        for (int k = 0; k < DEPTH + 2; k++) step(3'd4, 8'h00, 15'h0);
        step(3'd4, 8'h00, 15'h0);

        // R5 call from the top address wraps the saved return to zero
        step(3'd2, 8'h00, 15'h7FFF);
        step(3'd3, 8'h00, 15'h0444);
        step(3'd4, 8'h00, 15'h0);

        // R12: reset in the middle of a call cycle wins
        step(3'd3, 8'h00, 15'h0600);
        step(3'd3, 8'h00, 15'h0700);
        @(negedge clk);
        op_i = 3'd3; target_i = 15'h0abc;
        #2 rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R12 pc cleared by reset", int'(pc_o), 0);
        chk("R12 stack emptied by reset", int'(stk_empty_o), 1);
        @(negedge clk);
        op_i = 3'd0;
        rst_n = 1'b1;
        m_pc = '0; m_cnt = 0;
        step(3'd4, 8'h00, 15'h0);
        step(3'd1, 8'h00, 15'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule